// File: doc/BRIEF.md
# Burst-Gated Word Acceptor

This block sits between a rotating word buffer and a set of storage sections. Each slot may present one 33-bit word. The block checks the word's parity and decodes its address fields. It then compares the word's burst tag with a local burst counter that steps at a fixed interval and returns to zero on a longer frame period. One cycle later it returns a verdict to the buffer: accept, error (the buffer frees the slot), or defer (the word stays in the buffer and is offered again later).

An accepted word becomes a single-cycle store request. The request carries a one-hot section select, a register index and the 16-bit payload. Three saturating counters record the accept, parity-error and defer verdicts. The block paces writes so that one section never receives stores in two consecutive cycles. A word that would break this pacing is deferred and offered again on a later slot.

Top module: `burst_word_acceptor`

## Requirements
- R1: A word is valid only if the count of ones over all 33 bits (bit 32 is the parity bit) is odd. An even count gives the error verdict 2'b10, causes no store, and increments the parity-error counter.
- R2: Field positions: bits 31:29 are the section, bits 28:24 are the register index, bits 23:16 are the burst tag, and bits 15:0 are the payload carried to the store.
- R3: A word with good parity whose section is NUM_SECTIONS (3) or more, or whose register index is NUM_REGS (26) or more, gets the error verdict 2'b10 and causes no store.
- R4: A word with good parity and valid addresses whose burst tag equals the current burst gets the accept verdict 2'b01. It also raises store_o for one cycle, with store_sel_o one-hot at the section's bit, store_reg_o set to the register index and store_data_o set to the payload. This holds unless R11 applies.
- R5: A word with good parity and valid addresses whose burst tag is numerically greater than the current burst gets the defer verdict 2'b11 and causes no store.
- R6: A word with good parity and valid addresses whose burst tag is numerically smaller than the current burst gets the error verdict 2'b10. It causes no store and leaves the parity-error counter unchanged.
- R7: The verdict and the store request appear in the cycle after the word is presented. The verdict is judged against the burst value shown on burst_o in the cycle the word was presented. A cycle with no word gives verdict 2'b00 and no store.
- R8: burst_o advances by one (mod 256) every STEP_CYCLES cycles. It returns to 0 every FRAME_CYCLES cycles, counted from reset.
- R9: The accept, parity-error and defer counters each increment once per matching verdict and saturate at 2^CNT_W-1. The defer counter includes deferrals caused by R11.
- R10: During and right after reset, the verdict is 2'b00, store_o is low, burst_o is 0 and all counters are 0.
- R11: A word that would be accepted is given the defer verdict 2'b11, with no store, when the previous cycle issued a store to the same section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A word is presented this slot |
| word_i | input | 33 | Parity bit 32 and 32 data bits |
| verdict_o | output | 2 | 00 none, 01 accept, 10 error/free, 11 defer |
| store_o | output | 1 | Single-cycle store request |
| store_sel_o | output | NUM_SECTIONS | One-hot target section |
| store_reg_o | output | 5 | Register index inside the section |
| store_data_o | output | 16 | Payload to store |
| burst_o | output | 8 | Current burst number |
| cnt_accept_o | output | CNT_W | Saturating count of accepts |
| cnt_parity_o | output | CNT_W | Saturating count of parity errors |
| cnt_defer_o | output | CNT_W | Saturating count of defers |

## Verification
Assertions check the following on every cycle: the burst counter only moves forward by one or drops to zero, a store always has a one-hot select and an accept verdict, two consecutive stores never target the same section, an even-parity word always draws an error verdict, and counters never move backwards. Other behaviours need the bench's scenarios against its own model. These are the three-way burst comparison near the counter's wrap and frame reset, the address-range rejections, the payload and register routing, the pacing defer, and counter saturation.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    localparam int SEC_W   = 3;
    localparam int REG_W   = 5;
    localparam int BURST_W = 8;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = 1 + SEC_W + REG_W + BURST_W + DATA_W;

    typedef enum logic [1:0] {
        VERD_NONE   = 2'b00,
        VERD_ACCEPT = 2'b01,
        VERD_ERROR  = 2'b10,
        VERD_DEFER  = 2'b11
    } verdict_e;
endpackage

// File: rtl/bwa_burst_timer.sv
module bwa_burst_timer #(
    parameter int STEP_CYCLES  = 1024,
    parameter int FRAME_CYCLES = 262144
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [bwa_pkg::BURST_W-1:0] burst_o
);
    localparam int STEP_W  = $clog2(STEP_CYCLES);
    localparam int FRAME_W = $clog2(FRAME_CYCLES);

    typedef struct packed {
        logic [STEP_W-1:0]           step;
        logic [FRAME_W-1:0]          frame;
        logic [bwa_pkg::BURST_W-1:0] burst;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.frame == FRAME_W'(FRAME_CYCLES - 1)) begin
            st_d.frame = '0;
            st_d.step  = '0;
            st_d.burst = '0;
        end else begin
            st_d.frame = st_q.frame + 1'b1;
            if (st_q.step == STEP_W'(STEP_CYCLES - 1)) begin
                st_d.step  = '0;
                st_d.burst = st_q.burst + 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign burst_o = st_q.burst;

    assert_burst_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_o != $past(burst_o)) |-> (burst_o == $past(burst_o) + 8'd1 || burst_o == '0));
endmodule

// File: rtl/bwa_sat_counter.sv
module bwa_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && (st_q.count != {CNT_W{1'b1}}))
            st_d.count = st_q.count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    assert_count_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_o >= $past(count_o));
endmodule

// File: rtl/bwa_decode.sv
module bwa_decode #(
    parameter int NUM_SECTIONS = 3,
    parameter int NUM_REGS     = 26
) (
    input  logic [bwa_pkg::WORD_W-1:0]  word_i,
    input  logic [bwa_pkg::BURST_W-1:0] cur_burst_i,
    input  logic                        prev_store_i,
    input  logic [bwa_pkg::SEC_W-1:0]   prev_sec_i,
    output bwa_pkg::verdict_e           verdict_o,
    output logic                        parity_bad_o,
    output logic [bwa_pkg::SEC_W-1:0]   sec_o,
    output logic [bwa_pkg::REG_W-1:0]   reg_o,
    output logic [bwa_pkg::DATA_W-1:0]  data_o
);
    import bwa_pkg::*;

    localparam int SEC_LSB   = DATA_W + BURST_W + REG_W;
    localparam int REG_LSB   = DATA_W + BURST_W;
    localparam int BURST_LSB = DATA_W;

    logic [BURST_W-1:0] tag;
    logic               addr_ok;

    always_comb begin
        sec_o        = word_i[SEC_LSB +: SEC_W];
        reg_o        = word_i[REG_LSB +: REG_W];
        tag          = word_i[BURST_LSB +: BURST_W];
        data_o       = word_i[DATA_W-1:0];
        parity_bad_o = ~(^word_i);
        addr_ok      = (int'(sec_o) < NUM_SECTIONS) && (int'(reg_o) < NUM_REGS);

        if (parity_bad_o)              verdict_o = VERD_ERROR;
        else if (!addr_ok)             verdict_o = VERD_ERROR;
        else if (tag < cur_burst_i)    verdict_o = VERD_ERROR;
        else if (tag > cur_burst_i)    verdict_o = VERD_DEFER;
        else if (prev_store_i && prev_sec_i == sec_o)
                                       verdict_o = VERD_DEFER;
        else                           verdict_o = VERD_ACCEPT;
    end
endmodule

// File: rtl/burst_word_acceptor.sv
module burst_word_acceptor #(
    parameter int NUM_SECTIONS = 3,
    parameter int NUM_REGS     = 26,
    parameter int STEP_CYCLES  = 1024,
    parameter int FRAME_CYCLES = 262144,
    parameter int CNT_W        = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_valid_i,
    input  logic [bwa_pkg::WORD_W-1:0]    word_i,
    output logic [1:0]                    verdict_o,
    output logic                          store_o,
    output logic [NUM_SECTIONS-1:0]       store_sel_o,
    output logic [bwa_pkg::REG_W-1:0]     store_reg_o,
    output logic [bwa_pkg::DATA_W-1:0]    store_data_o,
    output logic [bwa_pkg::BURST_W-1:0]   burst_o,
    output logic [CNT_W-1:0]              cnt_accept_o,
    output logic [CNT_W-1:0]              cnt_parity_o,
    output logic [CNT_W-1:0]              cnt_defer_o
);
    import bwa_pkg::*;

    localparam int NUM_CNT = 3;

    typedef struct packed {
        verdict_e                verdict;
        logic                    store;
        logic [NUM_SECTIONS-1:0] sel;
        logic [SEC_W-1:0]        sec;
        logic [REG_W-1:0]        rsel;
        logic [DATA_W-1:0]       data;
    } acc_t;

    acc_t st_d, st_q;

    verdict_e                dec_verdict;
    logic                    dec_par_bad;
    logic [SEC_W-1:0]        dec_sec;
    logic [REG_W-1:0]        dec_reg;
    logic [DATA_W-1:0]       dec_data;
    logic [NUM_SECTIONS-1:0] hot;
    logic [NUM_CNT-1:0]      cnt_inc;
    logic [CNT_W-1:0]        cnt_val [NUM_CNT];

    bwa_burst_timer #(
        .STEP_CYCLES (STEP_CYCLES),
        .FRAME_CYCLES(FRAME_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .burst_o(burst_o)
    );

    bwa_decode #(
        .NUM_SECTIONS(NUM_SECTIONS),
        .NUM_REGS    (NUM_REGS)
    ) u_decode (
        .word_i      (word_i),
        .cur_burst_i (burst_o),
        .prev_store_i(st_q.store),
        .prev_sec_i  (st_q.sec),
        .verdict_o   (dec_verdict),
        .parity_bad_o(dec_par_bad),
        .sec_o       (dec_sec),
        .reg_o       (dec_reg),
        .data_o      (dec_data)
    );

    for (genvar s = 0; s < NUM_SECTIONS; s++) begin : g_sel
        assign hot[s] = (dec_sec == SEC_W'(s));
    end

    always_comb begin
        st_d         = st_q;
        st_d.verdict = VERD_NONE;
        st_d.store   = 1'b0;
        if (word_valid_i) begin
            st_d.verdict = dec_verdict;
            if (dec_verdict == VERD_ACCEPT) begin
                st_d.store = 1'b1;
                st_d.sel   = hot;
                st_d.sec   = dec_sec;
                st_d.rsel  = dec_reg;
                st_d.data  = dec_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_inc[0] = word_valid_i && (dec_verdict == VERD_ACCEPT);
    assign cnt_inc[1] = word_valid_i && dec_par_bad;
    assign cnt_inc[2] = word_valid_i && (dec_verdict == VERD_DEFER);

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        bwa_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (cnt_inc[c]),
            .count_o(cnt_val[c])
        );
    end

    assign verdict_o    = st_q.verdict;
    assign store_o      = st_q.store;
    assign store_sel_o  = st_q.store ? st_q.sel : '0;
    assign store_reg_o  = st_q.rsel;
    assign store_data_o = st_q.data;
    assign cnt_accept_o = cnt_val[0];
    assign cnt_parity_o = cnt_val[1];
    assign cnt_defer_o  = cnt_val[2];

    assert_store_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> ($countones(store_sel_o) == 1 && verdict_o == VERD_ACCEPT));

    assert_no_store_without_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_o != VERD_ACCEPT) |-> !store_o);

    assert_verdict_follows_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_o != VERD_NONE) |-> $past(word_valid_i));

    assert_parity_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && !(^word_i)) |=> (verdict_o == VERD_ERROR && !store_o));

    assert_section_pacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o && $past(store_o)) |-> (store_sel_o != $past(store_sel_o)));
endmodule

// File: tb/burst_word_acceptor_test.sv
`timescale 1ns/1ps
module burst_word_acceptor_test;
    localparam int NSEC  = 3;
    localparam int NREG  = 26;
    localparam int STEP  = 16;
    localparam int FRAME = 16 * 300;
    localparam int CW    = 6;
    localparam int CMAX  = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            word_valid_i = 1'b0;
    logic [32:0]     word_i = '0;
    logic [1:0]      verdict_o;
    logic            store_o;
    logic [NSEC-1:0] store_sel_o;
    logic [4:0]      store_reg_o;
    logic [15:0]     store_data_o;
    logic [7:0]      burst_o;
    logic [CW-1:0]   cnt_accept_o, cnt_parity_o, cnt_defer_o;

    burst_word_acceptor #(
        .NUM_SECTIONS(NSEC), .NUM_REGS(NREG), .STEP_CYCLES(STEP),
        .FRAME_CYCLES(FRAME), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid_i), .word_i(word_i),
        .verdict_o(verdict_o), .store_o(store_o), .store_sel_o(store_sel_o),
        .store_reg_o(store_reg_o), .store_data_o(store_data_o), .burst_o(burst_o),
        .cnt_accept_o(cnt_accept_o), .cnt_parity_o(cnt_parity_o), .cnt_defer_o(cnt_defer_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int edges  = 0;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    logic [1:0]  e_verd = 2'b00;
    logic        e_store = 1'b0;
    logic [2:0]  e_sec = '0;
    logic [4:0]  e_reg = '0;
    logic [15:0] e_data = '0;
    string       e_req = "R7";
    int          m_acc = 0, m_par = 0, m_def = 0;

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [32:0] mk(input logic [2:0] s, input logic [4:0] r,
                                       input logic [7:0] b, input logic [15:0] d,
                                       input bit bad);
        logic [31:0] w;
        w = {s, r, b, d};
        return {(~(^w)) ^ bad, w};
    endfunction

    function automatic int sat(input int v);
        return (v < CMAX) ? v + 1 : CMAX;
    endfunction

    function automatic int burst_model(input int n);
        return ((n % FRAME) / STEP) % 256;
    endfunction

    // check outputs of the previous slot, then present the next word (or none)
    task automatic slot(input bit valid, input logic [32:0] w);
        logic [1:0] v;
        logic [2:0] s;
        logic [7:0] tag;
        @(negedge clk);
        chk(e_req, verdict_o, e_verd, "verdict");
        chk(e_req, store_o, e_store, "store");
        if (e_store) begin
            chk("R4", store_sel_o, 1 << e_sec, "select");
            chk("R2", store_reg_o, e_reg, "register");
            chk("R2", store_data_o, e_data, "payload");
        end
        chk("R9", cnt_accept_o, m_acc, "accept count");
        chk("R9", cnt_parity_o, m_par, "parity count");
        chk("R9", cnt_defer_o, m_def, "defer count");
        chk("R8", burst_o, burst_model(edges), "burst");
        s   = w[31:29];
        tag = w[23:16];
        if (!valid) begin
            v = 2'b00; e_req = "R7";
        end else if (!(^w)) begin
            v = 2'b10; e_req = "R1"; m_par = sat(m_par);
        end else if (int'(s) >= NSEC || int'(w[28:24]) >= NREG) begin
            v = 2'b10; e_req = "R3";
        end else if (tag < burst_o) begin
            v = 2'b10; e_req = "R6";
        end else if (tag > burst_o) begin
            v = 2'b11; e_req = "R5"; m_def = sat(m_def);
        end else if (e_store && e_sec == s) begin
            v = 2'b11; e_req = "R11"; m_def = sat(m_def);
        end else begin
            v = 2'b01; e_req = "R4"; m_acc = sat(m_acc);
        end
        e_verd  = v;
        e_store = (v == 2'b01);
        if (e_store) begin
            e_sec = s; e_reg = w[28:24]; e_data = w[15:0];
        end
        word_valid_i = valid;
        word_i       = w;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (4) @(negedge clk);
        chk("R10", verdict_o, 0, "reset verdict");
        chk("R10", store_o, 0, "reset store");
        chk("R10", burst_o, 0, "reset burst");
        chk("R10", cnt_accept_o + cnt_parity_o + cnt_defer_o, 0, "reset counters");
        rst_n = 1'b1;
        // directed corners at burst 0
        slot(1, mk(3'd0, 5'd0, 8'd0, 16'hA5C3, 0));   // R4 accept
        slot(1, mk(3'd0, 5'd1, 8'd0, 16'h1111, 0));   // R11 same section next cycle
        slot(1, mk(3'd1, 5'd25, 8'd0, 16'hFFFF, 0));  // R4 last register
        slot(1, mk(3'd2, 5'd3, 8'd0, 16'h0001, 1));   // R1 bad parity
        slot(1, mk(3'd2, 5'd3, 8'd1, 16'h0002, 0));   // R5 too soon
        slot(1, mk(3'd3, 5'd3, 8'd0, 16'h0003, 0));   // R3 bad section
        slot(1, mk(3'd2, 5'd26, 8'd0, 16'h0004, 0));  // R3 bad register
        slot(0, '0);                                  // R7 no word
        while (burst_o < 8'd2) slot(0, '0);
        slot(1, mk(3'd1, 5'd7, 8'd0, 16'h7777, 0));   // R6 stale
        slot(1, mk(3'd1, 5'd7, burst_o, 16'h7070, 0));
        // random run across wrap and frame reset
        for (int i = 0; i < 9000; i++) begin
            logic [2:0] s;
            logic [4:0] r;
            logic [7:0] b;
            s = 3'(($urandom % 8 < 7) ? $urandom % 3 : 3);
            r = 5'(($urandom % 10 < 9) ? $urandom % 26 : 26 + $urandom % 6);
            b = burst_o + 8'($urandom % 5) - 8'd2;
            slot(($urandom % 5) != 0, mk(s, r, b, 16'($urandom), ($urandom % 8) == 0));
        end
        slot(0, '0);
        slot(0, '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule